// File: doc/BRIEF.md
# Linked-Descriptor DMA Channel

This block is one channel of a DMA engine. It moves data between a device address that stays fixed and a memory address that advances after every beat. Software either loads the four descriptor words straight into the channel and starts a single transfer, or points the channel at a list of descriptors in memory. In that case the channel reads each descriptor over the bus, carries out the transfer it describes and then follows the link to the next one. Each beat is one bus read from the source followed by one bus write to the destination. The bus is single-beat: the request is held until an acknowledge or an error comes back.

A descriptor is four 32-bit words, fetched at offsets 0, 4, 8 and 12 from its base. They are, in that order, the device address, the memory address, the size word and the link word. The size word carries the beat width and the byte count. The two low bits of the link word say whether the descriptor ends the list or is followed by another, and whether an interrupt pulse is raised when it completes. The channel reports its state on a 2-bit output. Its states are CH_IDLE (0), CH_FETCH (1, descriptor read), CH_WAIT (2, between beats) and CH_ACCESS (3, a beat in progress). It signals completion and bus faults with one-cycle pulses.

The transitions are as follows. CH_IDLE goes to CH_WAIT on a start in single mode, and to CH_FETCH on a start in chain mode. CH_FETCH goes to CH_WAIT after the fourth word is acknowledged, and to CH_IDLE on a bus error. CH_WAIT goes to CH_ACCESS while beats remain. When the descriptor's beats are done, CH_WAIT goes to CH_FETCH on a follow link in chain mode and otherwise to CH_IDLE. CH_WAIT also goes to CH_IDLE at once when the mode input is off. CH_ACCESS goes back to CH_WAIT after the write of the beat is acknowledged, and to CH_IDLE on a bus error.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset the channel reports state 0, and the bus request, interrupt and error outputs are low.
- R2: The state output reads 0 when idle, 1 while fetching a descriptor, 2 between beats and 3 while a beat is on the bus.
- R3: A start pulse in single mode (mode 2) loads the four descriptor inputs and transfers from them without any descriptor fetch. A start is ignored in mode 0 or mode 3, and it is ignored whenever the channel is not idle.
- R4: A start pulse in chain mode (mode 1) fetches four words from the link input with its two low bits cleared, at offsets 0, 4, 8 and 12. The words are taken as device address, memory address, size and link, in that order.
- R5: Size bits [13:12] select the beat width: 3 gives 1 byte, 2 gives 2 bytes, and 0 or 1 gives 4 bytes. The byte count is size[9:0] for the 1-byte and 2-byte widths and size[10:0] for the 4-byte width. The beat count is the byte count divided by the width, rounded down. A beat count of zero ends the descriptor without any bus access.
- R6: Each beat reads the source and then writes the data just read to the destination. With direction 1 the source is memory and the destination is the device; with direction 0 the roles are reversed.
- R7: The memory address advances by the beat width after every beat, and the device address is the same for every beat of a descriptor.
- R8: When a descriptor completes and link bit 0 is 1, the interrupt output pulses for one cycle. In chain mode, link bit 1 set causes the next descriptor to be fetched from link[31:2]*4 without passing through idle. In single mode, and whenever link bit 1 is 0, the channel returns to idle.
- R9: A bus error during a fetch or an access raises interrupt and error together for one cycle and returns the channel to idle, with no further bus request.
- R10: Setting the mode to 0 while the channel is busy lets the beat in flight finish, then returns the channel to idle with no interrupt.
- R11: While the request is high and neither acknowledge nor error is seen, the address and write-enable hold steady into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request, sampled while idle |
| mode_i | input | 2 | 0 off/abort, 1 chain, 2 single, 3 treated as off at start |
| dir_i | input | 1 | 1 memory to device, 0 device to memory; latched at start |
| ld_dev_i | input | 32 | Loaded device address word |
| ld_mem_i | input | 32 | Loaded memory address word |
| ld_size_i | input | 32 | Loaded size word |
| ld_link_i | input | 32 | Loaded link word; the first descriptor pointer in chain mode |
| bus_req_o | output | 1 | Bus request |
| bus_we_o | output | 1 | Bus write enable |
| bus_addr_o | output | 32 | Bus byte address |
| bus_wdata_o | output | 32 | Bus write data |
| bus_rdata_i | input | 32 | Bus read data, valid with acknowledge |
| bus_ack_i | input | 1 | Bus acknowledge |
| bus_err_i | input | 1 | Bus error response |
| state_o | output | 2 | Channel state code |
| irq_o | output | 1 | One-cycle interrupt pulse |
| err_o | output | 1 | One-cycle bus error pulse |

## Verification
Two situations are hard to reach from the ports. One is a bus fault at a chosen point inside a chain, where the fetch or beat that fails must be the last transaction seen. The other is an abort that arrives while a beat is half done. The bench bus model counts the completed transactions and answers the N-th one with an error instead of an acknowledge, so any fetch word or beat half can be made to fail. The abort is made by clearing the mode a fixed number of cycles into a long transfer. The bench then requires an even transaction count, which shows every beat started was finished, and requires that no interrupt was raised.

// File: rtl/dmac_pkg.sv
package dmac_pkg;
    localparam int WORD_W       = 32;
    localparam int DESC_WORDS   = 4;
    localparam int IDX_W        = $clog2(DESC_WORDS);
    localparam int CNT_W        = 11;
    localparam int NARROW_CNT_W = 10;
    localparam int STEP_W       = 3;
    localparam int WSEL_LSB     = 12;

    localparam int W_DEV  = 0;
    localparam int W_MEM  = 1;
    localparam int W_SIZE = 2;
    localparam int W_LINK = 3;

    localparam int LINK_IRQ_BIT    = 0;
    localparam int LINK_FOLLOW_BIT = 1;

    localparam logic [1:0] WSEL_BYTE = 2'd3;
    localparam logic [1:0] WSEL_HALF = 2'd2;

    localparam logic [1:0] MODE_OFF    = 2'd0;
    localparam logic [1:0] MODE_CHAIN  = 2'd1;
    localparam logic [1:0] MODE_SINGLE = 2'd2;

    typedef enum logic [1:0] {
        CH_IDLE   = 2'd0,
        CH_FETCH  = 2'd1,
        CH_WAIT   = 2'd2,
        CH_ACCESS = 2'd3
    } ch_state_e;
endpackage

// File: rtl/dmac_size_decode.sv
module dmac_size_decode
    import dmac_pkg::*;
(
    input  logic [WORD_W-1:0] size_word_i,
    output logic [STEP_W-1:0] step_o,
    output logic [CNT_W-1:0]  beats_o
);
    logic [1:0]       wsel;
    logic [CNT_W-1:0] narrow_bytes;
    logic [CNT_W-1:0] wide_bytes;
    logic             size_unused;

    assign wsel         = size_word_i[WSEL_LSB +: 2];
    assign narrow_bytes = {{(CNT_W-NARROW_CNT_W){1'b0}}, size_word_i[NARROW_CNT_W-1:0]};
    assign wide_bytes   = size_word_i[CNT_W-1:0];
    assign size_unused  = ^{size_word_i[WORD_W-1:WSEL_LSB+2], size_word_i[WSEL_LSB-1:CNT_W]};

    always_comb begin
        case (wsel)
            WSEL_BYTE: begin
                step_o  = STEP_W'(1);
                beats_o = narrow_bytes;
            end
            WSEL_HALF: begin
                step_o  = STEP_W'(2);
                beats_o = narrow_bytes >> 1;
            end
            default: begin
                step_o  = STEP_W'(4);
                beats_o = wide_bytes >> 2;
            end
        endcase
    end
endmodule

// File: rtl/dmac_desc_file.sv
module dmac_desc_file
    import dmac_pkg::*;
(
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                load_all_i,
    input  logic [DESC_WORDS-1:0][WORD_W-1:0]   load_words_i,
    input  logic                                fetch_we_i,
    input  logic [IDX_W-1:0]                    fetch_idx_i,
    input  logic [WORD_W-1:0]                   fetch_data_i,
    input  logic                                step_en_i,
    input  logic [STEP_W-1:0]                   step_i,
    output logic [DESC_WORDS-1:0][WORD_W-1:0]   words_o
);
    for (genvar w = 0; w < DESC_WORDS; w++) begin : g_word
        logic fetch_hit;
        assign fetch_hit = fetch_we_i && (fetch_idx_i == IDX_W'(w));
        if (w == W_MEM) begin : g_stepping
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    words_o[w] <= '0;
                else if (load_all_i)
                    words_o[w] <= load_words_i[w];
                else if (fetch_hit)
                    words_o[w] <= fetch_data_i;
                else if (step_en_i)
                    words_o[w] <= words_o[w] + WORD_W'(step_i);
            end
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    words_o[w] <= '0;
                else if (load_all_i)
                    words_o[w] <= load_words_i[w];
                else if (fetch_hit)
                    words_o[w] <= fetch_data_i;
            end
        end
    end
endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
    import dmac_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [1:0]        mode_i,
    input  logic              dir_i,
    input  logic [WORD_W-1:0] ld_dev_i,
    input  logic [WORD_W-1:0] ld_mem_i,
    input  logic [WORD_W-1:0] ld_size_i,
    input  logic [WORD_W-1:0] ld_link_i,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [WORD_W-1:0] bus_addr_o,
    output logic [WORD_W-1:0] bus_wdata_o,
    input  logic [WORD_W-1:0] bus_rdata_i,
    input  logic              bus_ack_i,
    input  logic              bus_err_i,
    output logic [1:0]        state_o,
    output logic              irq_o,
    output logic              err_o
);
    ch_state_e state_q, state_d;

    logic [IDX_W-1:0]                  word_idx_q;
    logic                              phase_q;
    logic [CNT_W-1:0]                  beat_q;
    logic [WORD_W-1:0]                 data_q;
    logic                              chain_q;
    logic                              dir_q;
    logic                              irq_q;
    logic                              err_q;
    logic [DESC_WORDS-1:0][WORD_W-1:0] words;
    logic [DESC_WORDS-1:0][WORD_W-1:0] load_words;
    logic [STEP_W-1:0]                 step;
    logic [CNT_W-1:0]                  beats;

    logic start_go, bus_fault, bus_done, fetch_we, step_en;
    logic desc_done, follow, abort;
    logic [WORD_W-1:0] fetch_addr;

    assign load_words[W_DEV]  = ld_dev_i;
    assign load_words[W_MEM]  = ld_mem_i;
    assign load_words[W_SIZE] = ld_size_i;
    assign load_words[W_LINK] = ld_link_i;

    assign start_go  = (state_q == CH_IDLE) && start_i &&
                       ((mode_i == MODE_CHAIN) || (mode_i == MODE_SINGLE));
    assign bus_fault = bus_req_o && bus_err_i;
    assign bus_done  = bus_req_o && bus_ack_i && !bus_err_i;
    assign fetch_we  = (state_q == CH_FETCH) && bus_done;
    assign step_en   = (state_q == CH_ACCESS) && phase_q && bus_done;
    assign abort     = (state_q == CH_WAIT) && (mode_i == MODE_OFF);
    assign desc_done = (state_q == CH_WAIT) && !abort && (beat_q == beats);
    assign follow    = chain_q && words[W_LINK][LINK_FOLLOW_BIT];

    assign fetch_addr = {words[W_LINK][WORD_W-1:2], 2'b00} +
                        {{(WORD_W-IDX_W-2){1'b0}}, word_idx_q, 2'b00};

    dmac_size_decode u_size (
        .size_word_i (words[W_SIZE]),
        .step_o      (step),
        .beats_o     (beats)
    );

    dmac_desc_file u_desc (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_all_i   (start_go),
        .load_words_i (load_words),
        .fetch_we_i   (fetch_we),
        .fetch_idx_i  (word_idx_q),
        .fetch_data_i (bus_rdata_i),
        .step_en_i    (step_en),
        .step_i       (step),
        .words_o      (words)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            CH_IDLE: begin
                if (start_go)
                    state_d = (mode_i == MODE_CHAIN) ? CH_FETCH : CH_WAIT;
            end
            CH_FETCH: begin
                if (bus_fault)
                    state_d = CH_IDLE;
                else if (fetch_we && (word_idx_q == IDX_W'(DESC_WORDS-1)))
                    state_d = CH_WAIT;
            end
            CH_WAIT: begin
                if (abort)
                    state_d = CH_IDLE;
                else if (desc_done)
                    state_d = follow ? CH_FETCH : CH_IDLE;
                else
                    state_d = CH_ACCESS;
            end
            CH_ACCESS: begin
                if (bus_fault)
                    state_d = CH_IDLE;
                else if (step_en)
                    state_d = CH_WAIT;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= CH_IDLE;
        else
            state_q <= state_d;
    end

    // per-state working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_idx_q <= '0;
            phase_q    <= 1'b0;
            beat_q     <= '0;
            data_q     <= '0;
            chain_q    <= 1'b0;
            dir_q      <= 1'b0;
            irq_q      <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            irq_q <= (desc_done && words[W_LINK][LINK_IRQ_BIT]) || bus_fault;
            err_q <= bus_fault;
            if (start_go) begin
                chain_q <= (mode_i == MODE_CHAIN);
                dir_q   <= dir_i;
            end
            if (start_go || desc_done)
                word_idx_q <= '0;
            else if (fetch_we)
                word_idx_q <= word_idx_q + IDX_W'(1);
            if ((state_d == CH_WAIT) && (state_q != CH_WAIT) && (state_q != CH_ACCESS))
                beat_q <= '0;
            else if (step_en)
                beat_q <= beat_q + CNT_W'(1);
            if (state_q != CH_ACCESS)
                phase_q <= 1'b0;
            else if (bus_done)
                phase_q <= !phase_q;
            if ((state_q == CH_ACCESS) && !phase_q && bus_done)
                data_q <= bus_rdata_i;
        end
    end

    // outputs
    always_comb begin
        bus_req_o   = 1'b0;
        bus_we_o    = 1'b0;
        bus_addr_o  = '0;
        bus_wdata_o = '0;
        unique case (state_q)
            CH_IDLE, CH_WAIT: begin
                bus_req_o = 1'b0;
            end
            CH_FETCH: begin
                bus_req_o  = 1'b1;
                bus_addr_o = fetch_addr;
            end
            CH_ACCESS: begin
                bus_req_o = 1'b1;
                if (!phase_q) begin
                    bus_addr_o = dir_q ? words[W_MEM] : words[W_DEV];
                end else begin
                    bus_we_o    = 1'b1;
                    bus_addr_o  = dir_q ? words[W_DEV] : words[W_MEM];
                    bus_wdata_o = data_q;
                end
            end
        endcase
    end

    assign state_o = state_q;
    assign irq_o   = irq_q;
    assign err_o   = err_q;

    AST_ERR_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> irq_o); // R9
    AST_ERR_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> (state_o == CH_IDLE) && !bus_req_o); // R9
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && !bus_ack_i && !bus_err_i) |=>
        (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o))); // R11
    AST_DEV_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_ACCESS) |=> $stable(words[W_DEV])); // R7
    AST_ABORT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_o == CH_WAIT) && (mode_i == MODE_OFF)) |=>
        ((state_o == CH_IDLE) && !irq_o)); // R10
endmodule

// File: tb/tb_dma_chain_channel.sv
module tb_dma_chain_channel;
    localparam int LOGN = 2200;
    localparam logic [31:0] KEY = 32'h5A5A_0000;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n;
    logic        start;
    logic [1:0]  mode;
    logic        dir;
    logic [31:0] ld_dev, ld_mem, ld_size, ld_link;
    logic        req, we, ack, berr;
    logic [31:0] addr, wdata, rdata;
    logic [1:0]  state;
    logic        irq, errp;

    dma_chain_channel dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .dir_i(dir),
        .ld_dev_i(ld_dev), .ld_mem_i(ld_mem), .ld_size_i(ld_size), .ld_link_i(ld_link),
        .bus_req_o(req), .bus_we_o(we), .bus_addr_o(addr), .bus_wdata_o(wdata),
        .bus_rdata_i(rdata), .bus_ack_i(ack), .bus_err_i(berr),
        .state_o(state), .irq_o(irq), .err_o(errp)
    );

    logic [31:0] desc_mem [64];
    always_comb
        rdata = (addr[31:8] == 24'h000010) ? desc_mem[addr[7:2]] : (addr ^ KEY);

    int err_at = -1;
    int log_n, irq_n, err_n;
    logic [3:0] seen;
    logic clr = 1'b0;
    logic [31:0] log_addr [LOGN];
    logic [31:0] log_data [LOGN];
    logic        log_we   [LOGN];

    always @(posedge clk) begin
        if (!rst_n) begin
            ack  <= 1'b0;
            berr <= 1'b0;
        end else if (req && !ack && !berr) begin
            if (log_n == err_at) berr <= 1'b1;
            else                 ack  <= 1'b1;
        end else begin
            ack  <= 1'b0;
            berr <= 1'b0;
        end
    end

    always @(negedge clk) begin
        if (clr) begin
            log_n = 0; irq_n = 0; err_n = 0; seen = 4'b0;
        end else begin
            if (req && (ack || berr)) begin
                if (log_n < LOGN) begin
                    log_addr[log_n] = addr;
                    log_data[log_n] = wdata;
                    log_we[log_n]   = we;
                end
                log_n++;
            end
            if (irq)  irq_n++;
            if (errp) err_n++;
            seen[state] = 1'b1;
        end
    end

    int n_chk = 0, n_fail = 0;
    logic [31:0] exp_addr [LOGN];
    logic [31:0] exp_data [LOGN];
    logic        exp_we   [LOGN];
    int exp_n;

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic push(input logic [31:0] a, input logic w, input logic [31:0] d);
        if (exp_n < LOGN) begin
            exp_addr[exp_n] = a; exp_we[exp_n] = w; exp_data[exp_n] = d;
        end
        exp_n++;
    endtask

    task automatic push_beats(input logic d, input logic [31:0] dev, input logic [31:0] mem,
                              input int step, input int nb);
        for (int k = 0; k < nb; k++) begin
            logic [31:0] m, s, t;
            m = mem + 32'(k * step);
            s = d ? m : dev;
            t = d ? dev : m;
            push(s, 1'b0, 32'h0);
            push(t, 1'b1, s ^ KEY);
        end
    endtask

    task automatic push_fetch(input logic [31:0] base);
        for (int i = 0; i < 4; i++) push(base + 32'(4 * i), 1'b0, 32'h0);
    endtask

    task automatic clear_all();
        exp_n = 0;
        err_at = -1;
        @(negedge clk);
        clr = 1'b1;
        @(posedge clk);
        #1 clr = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_idle();
        int g = 0;
        while (state != 2'd0 && g < 30000) begin
            @(negedge clk);
            g++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic compare(input string tag, input bit prefix);
        int bad = 0;
        int first = -1;
        int n;
        n = prefix ? log_n : exp_n;
        if (n > LOGN) n = LOGN;
        if (!prefix) chk(log_n == exp_n, {tag, " transaction count"}, log_n, exp_n);
        for (int i = 0; i < n; i++) begin
            if (log_addr[i] !== exp_addr[i] || log_we[i] !== exp_we[i] ||
                (exp_we[i] && log_data[i] !== exp_data[i])) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        chk(bad == 0, {tag, " transaction sequence"},
            (first >= 0) ? log_addr[first] : 0, (first >= 0) ? exp_addr[first] : 0);
    endtask

    function automatic int step_of(input logic [1:0] wc);
        return (wc == 2'd3) ? 1 : (wc == 2'd2) ? 2 : 4;
    endfunction

    function automatic int beats_of(input logic [1:0] wc, input int cnt);
        int c;
        c = wc[1] ? (cnt & 32'h3FF) : (cnt & 32'h7FF);
        return c / step_of(wc);
    endfunction

    // R3 R5 R6 R7 R8: one single-mode transfer checked against arithmetic expectations
    task automatic run_single(input logic d, input logic [1:0] wc, input int cnt,
                              input logic [1:0] lk, input string tag);
        clear_all();
        mode    = 2'd2;
        dir     = d;
        ld_dev  = 32'h8000_0040;
        ld_mem  = 32'h0000_4003;
        ld_size = (32'(wc) << 12) | 32'(cnt);
        ld_link = {30'h0000_0400, lk};
        pulse_start();
        wait_idle();
        push_beats(d, ld_dev, ld_mem, step_of(wc), beats_of(wc, cnt));
        compare({tag, " R5 R6 R7"}, 1'b0);
        chk(irq_n == int'(lk[0]), {tag, " R8 interrupt count"}, irq_n, lk[0]);
        chk(err_n == 0 && state == 2'd0, {tag, " R8 back to idle"}, state, 0);
        chk(seen[1] == 1'b0, {tag, " R3 no descriptor fetch"}, seen, 0);
    endtask

    initial begin
        rst_n = 1'b0; start = 1'b0; mode = 2'd2; dir = 1'b0;
        ld_dev = '0; ld_mem = '0; ld_size = '0; ld_link = '0;
        for (int i = 0; i < 64; i++) desc_mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        chk(state == 2'd0 && !req && !irq && !errp, "R1 reset outputs", {state, req, irq, errp}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(state == 2'd0 && !req, "R1 idle after reset release", state, 0);

        // near-exhaustive single-mode sweep
        for (int d = 0; d < 2; d++)
            for (int w = 0; w < 4; w++)
                for (int ci = 0; ci < 4; ci++)
                    for (int l = 0; l < 4; l++) begin
                        int cnt;
                        cnt = (ci == 0) ? 0 : (ci == 1) ? 1 : (ci == 2) ? 7 : 13;
                        run_single(d[0], w[1:0], cnt, l[1:0], "sweep");
                    end
        // R5 maximum counts, masked per width
        run_single(1'b1, 2'd3, 32'h7FF, 2'd1, "R5 max 1-byte");
        run_single(1'b0, 2'd0, 32'h7FF, 2'd0, "R5 max 4-byte");
        run_single(1'b1, 2'd2, 32'h7FF, 2'd3, "R5 max 2-byte");

        // R3: start ignored in modes 0 and 3
        for (int m = 0; m < 4; m += 3) begin
            clear_all();
            mode = m[1:0];
            ld_size = 32'h0000_0010;
            pulse_start();
            repeat (10) @(negedge clk);
            chk(log_n == 0 && state == 2'd0, "R3 start ignored in off mode", log_n, 0);
        end

        // R3: start while busy has no effect on the transfer in flight
        clear_all();
        mode = 2'd2; dir = 1'b1;
        ld_dev = 32'h8000_0100; ld_mem = 32'h0000_6000;
        ld_size = 32'h0000_0020; ld_link = 32'h1;
        pulse_start();
        repeat (12) @(negedge clk);
        ld_dev = 32'h8000_0F00; ld_mem = 32'h0000_7000; ld_size = 32'h0000_3005; dir = 1'b0;
        pulse_start();
        wait_idle();
        push_beats(1'b1, 32'h8000_0100, 32'h0000_6000, 4, 8);
        compare("R3 start while busy", 1'b0);
        chk(irq_n == 1, "R3 start while busy interrupt", irq_n, 1);

        // R4 R8 R2: three-descriptor chain in both directions
        desc_mem[0]  = 32'h8000_0010; desc_mem[1]  = 32'h0000_2000;
        desc_mem[2]  = 32'h0000_0008; desc_mem[3]  = 32'h0000_1013;
        desc_mem[4]  = 32'h8000_0020; desc_mem[5]  = 32'h0000_3001;
        desc_mem[6]  = 32'h0000_3003; desc_mem[7]  = 32'h0000_1022;
        desc_mem[8]  = 32'h8000_0030; desc_mem[9]  = 32'h0000_5000;
        desc_mem[10] = 32'h0000_2005; desc_mem[11] = 32'h0000_0001;
        for (int d = 0; d < 2; d++) begin
            clear_all();
            mode = 2'd1; dir = d[0];
            ld_link = 32'h0000_1002;
            pulse_start();
            wait_idle();
            push_fetch(32'h0000_1000);
            push_beats(d[0], 32'h8000_0010, 32'h0000_2000, 4, 2);
            push_fetch(32'h0000_1010);
            push_beats(d[0], 32'h8000_0020, 32'h0000_3001, 1, 3);
            push_fetch(32'h0000_1020);
            push_beats(d[0], 32'h8000_0030, 32'h0000_5000, 2, 2);
            compare("R4 R8 chain", 1'b0);
            chk(irq_n == 2, "R8 chain interrupt count", irq_n, 2);
            chk(seen == 4'b1111, "R2 all state codes seen", seen, 4'hF);
        end

        // R9: error on the third descriptor word
        desc_mem[16] = 32'h8000_0000; desc_mem[17] = 32'h0000_2000;
        desc_mem[18] = 32'h0000_0010; desc_mem[19] = 32'h0000_0001;
        clear_all();
        err_at = 2;
        mode = 2'd1; dir = 1'b1; ld_link = 32'h0000_1040;
        pulse_start();
        wait_idle();
        repeat (5) @(negedge clk);
        chk(log_n == 3, "R9 fetch error stops bus", log_n, 3);
        chk(irq_n == 1 && err_n == 1, "R9 fetch error pulses", {irq_n[7:0], err_n[7:0]}, 16'h0101);
        chk(state == 2'd0 && !req, "R9 fetch error idle", state, 0);

        // R9: error on the write half of the second beat
        clear_all();
        err_at = 3;
        mode = 2'd2; dir = 1'b1;
        ld_dev = 32'h8000_0040; ld_mem = 32'h0000_4000; ld_size = 32'h0000_0010; ld_link = 32'h0;
        pulse_start();
        wait_idle();
        repeat (5) @(negedge clk);
        exp_n = 0;
        push_beats(1'b1, 32'h8000_0040, 32'h0000_4000, 4, 2);
        compare("R9 access error", 1'b0);
        chk(irq_n == 1 && err_n == 1, "R9 access error pulses", {irq_n[7:0], err_n[7:0]}, 16'h0101);

        // R10: abort mid-transfer
        for (int delay = 29; delay < 33; delay++) begin
            clear_all();
            mode = 2'd2; dir = 1'b0;
            ld_dev = 32'h8000_0080; ld_mem = 32'h0000_8000; ld_size = 32'h0000_0100; ld_link = 32'h1;
            pulse_start();
            repeat (delay) @(negedge clk);
            mode = 2'd0;
            wait_idle();
            mode = 2'd2;
            push_beats(1'b0, 32'h8000_0080, 32'h0000_8000, 4, 64);
            compare("R10 abort prefix", 1'b1);
            chk(log_n % 2 == 0 && log_n > 0 && log_n < 128, "R10 abort at beat boundary", log_n, 0);
            chk(irq_n == 0 && err_n == 0 && state == 2'd0, "R10 abort quiet", irq_n, 0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule